// File: doc/BRIEF.md
# Pareto Strength Fitness Archiver

This block ranks a pool of candidate configurations against three cost figures: run time, energy and temperature. Lower is better for all three. Candidates arrive one per accepted beat on a valid/ready input. A beat flagged as last ends the pool, and so does reaching the pool capacity. The block then works out which members dominate which others. From that it derives each member's strength and raw fitness. It finally streams out an archive of fixed size, ordered from fittest to least fit.

A member dominates another when it is no worse on every cost and strictly better on at least one. A member's strength is the number of pool members it dominates. Its raw fitness is the total strength of all the members that dominate it, so a fitness of zero marks a non-dominated member. The archive is meant to hold the members of the current population together with the previous archive. A search controller therefore reloads the previous archive entries with the new population for each generation.

The work is split into one compare row per cycle, one fitness column per cycle and one archive pick per cycle. A pool of n members takes about 2n + 1 cycles to evaluate and then emits its archive on consecutive cycles.

Top module: `pareto_archiver`

## Requirements
- R1: Member A dominates member B when A's time, energy and temperature are each less than or equal to B's, and at least one of them is strictly less. Two members with identical costs do not dominate each other.
- R2: The strength reported with an archive entry equals the number of pool members that the entry dominates.
- R3: The fitness reported with an archive entry equals the sum of the strengths of all pool members that dominate it. It cannot exceed POOL_N*(POOL_N-1)/2, and the counters are wide enough to hold that bound at the maximum pool.
- R4: Every non-dominated member has fitness 0. The archive takes non-dominated members before any dominated one.
- R5: For a pool of n members the archive holds exactly min(n, ARC_N) entries. When there are more non-dominated members than archive slots, the members with the higher pool index are dropped.
- R6: Entries are emitted in ascending fitness order. Equal fitness is broken in favour of the lower pool index, so a shortfall of non-dominated members is filled with the fittest dominated ones.
- R7: in_ready is high only while a pool is being loaded. Loading ends on an accepted beat with in_last high, or on the POOL_N-th accepted beat. in_valid while in_ready is low has no effect on the results.
- R8: done is a one-cycle pulse once evaluation finishes. The first archive entry appears two cycles after done. The entries follow on consecutive cycles, out_last marks the final one, and out_valid then drops.
- R9: After reset in_ready is 1, and out_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Candidate beat is present |
| in_ready | output | 1 | Block accepts a candidate this cycle |
| in_last | input | 1 | Beat is the final member of the pool |
| in_time | input | OBJ_W | Run-time cost of the candidate |
| in_energy | input | OBJ_W | Energy cost of the candidate |
| in_temp | input | OBJ_W | Temperature cost of the candidate |
| done | output | 1 | One-cycle strobe: evaluation complete |
| out_valid | output | 1 | Archive entry is present |
| out_last | output | 1 | Entry is the final archive entry |
| out_idx | output | IDX_W | Pool index (load order) of the entry |
| out_strength | output | STR_W | Strength of the entry |
| out_fitness | output | FIT_W | Raw fitness of the entry |
| out_time | output | OBJ_W | Run-time cost of the entry |
| out_energy | output | OBJ_W | Energy cost of the entry |
| out_temp | output | OBJ_W | Temperature cost of the entry |

## Verification
The hardest case to reach from the ports is the top of the fitness range. It needs a full pool of 25 members arranged as a strict dominance chain, loaded without in_last so that the capacity limit ends the load. The last member then carries the maximum fitness of 300. Ties at the archive boundary are the other hard case. They come from pools of mutually non-dominated trade-off points, pools of identical members, and random pools whose costs are drawn from only four values, so that equal costs and equal fitness occur often. Stray input beats are driven while the block is evaluating, and the bench then checks that the archive still matches the loaded pool.

// File: rtl/pareto_pkg.sv
package pareto_pkg;
   typedef enum logic [2:0] {
      ST_LOAD,
      ST_ROW,
      ST_COL,
      ST_DONE,
      ST_EMIT
   } fsm_t;
endpackage

// File: rtl/pareto_cmp.sv
module pareto_cmp #(
   parameter int OBJ_W = 16
) (
   input  logic [OBJ_W-1:0] a_time,
   input  logic [OBJ_W-1:0] a_energy,
   input  logic [OBJ_W-1:0] a_temp,
   input  logic [OBJ_W-1:0] b_time,
   input  logic [OBJ_W-1:0] b_energy,
   input  logic [OBJ_W-1:0] b_temp,
   output logic             a_dom_b
);
   logic no_worse, some_better;
   always_comb begin
      no_worse    = (a_time <= b_time) && (a_energy <= b_energy) && (a_temp <= b_temp);
      some_better = (a_time <  b_time) || (a_energy <  b_energy) || (a_temp <  b_temp);
      a_dom_b     = no_worse && some_better;
   end
endmodule

// File: rtl/pareto_colsum.sv
module pareto_colsum #(
   parameter int N     = 25,
   parameter int STR_W = 5,
   parameter int FIT_W = 9
) (
   input  logic [N-1:0]     col,
   input  logic [STR_W-1:0] str [N],
   output logic [FIT_W-1:0] sum
);
   always_comb begin
      sum = '0;
      for (int j = 0; j < N; j++) begin
         if (col[j]) sum = sum + FIT_W'(str[j]);
      end
   end
endmodule

// File: rtl/pareto_pick.sv
module pareto_pick #(
   parameter int N     = 25,
   parameter int FIT_W = 9,
   parameter int IDX_W = 5
) (
   input  logic [N-1:0]     cand,
   input  logic [FIT_W-1:0] fit [N],
   output logic             found,
   output logic [IDX_W-1:0] sel
);
   logic [FIT_W-1:0] best;
   always_comb begin
      found = 1'b0;
      sel   = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         // strict compare keeps the lower index on equal fitness
         if (cand[i] && (!found || fit[i] < best)) begin
            found = 1'b1;
            sel   = IDX_W'(i);
            best  = fit[i];
         end
      end
   end
endmodule

// File: rtl/pareto_archiver.sv
module pareto_archiver
   import pareto_pkg::*;
#(
   parameter int OBJ_W  = 16,
   parameter int POP_N  = 20,
   parameter int ARC_N  = 5,
   localparam int POOL_N  = POP_N + ARC_N,
   localparam int IDX_W   = (POOL_N > 1) ? $clog2(POOL_N) : 1,
   localparam int CNT_W   = $clog2(POOL_N + 1),
   localparam int STR_W   = IDX_W,
   localparam int MAX_FIT = POOL_N * (POOL_N - 1) / 2,
   localparam int FIT_W   = (MAX_FIT > 1) ? $clog2(MAX_FIT + 1) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_last,
   input  logic [OBJ_W-1:0] in_time,
   input  logic [OBJ_W-1:0] in_energy,
   input  logic [OBJ_W-1:0] in_temp,
   output logic             done,
   output logic             out_valid,
   output logic             out_last,
   output logic [IDX_W-1:0] out_idx,
   output logic [STR_W-1:0] out_strength,
   output logic [FIT_W-1:0] out_fitness,
   output logic [OBJ_W-1:0] out_time,
   output logic [OBJ_W-1:0] out_energy,
   output logic [OBJ_W-1:0] out_temp
);
   if (OBJ_W < 1) begin : g_bad_obj
      $error("pareto_archiver: OBJ_W must be at least 1");
   end
   if (POP_N < 1 || ARC_N < 1) begin : g_bad_size
      $error("pareto_archiver: POP_N and ARC_N must be at least 1");
   end

   fsm_t             state_q;
   logic [CNT_W-1:0] cnt_q, emit_q;
   logic [IDX_W-1:0] ptr_q;
   logic [POOL_N-1:0] picked_q;

   logic [OBJ_W-1:0] t_q [POOL_N];
   logic [OBJ_W-1:0] e_q [POOL_N];
   logic [OBJ_W-1:0] h_q [POOL_N];
   logic [POOL_N-1:0] dom_q [POOL_N];
   logic [STR_W-1:0]  str_q [POOL_N];
   logic [FIT_W-1:0]  fit_q [POOL_N];

   logic [POOL_N-1:0] vmask, row_raw, row, col;
   logic [STR_W-1:0]  row_cnt;
   logic [FIT_W-1:0]  col_sum;
   logic              pick_found;
   logic [IDX_W-1:0]  pick_sel;
   logic [CNT_W-1:0]  arc_len;
   logic              ptr_end, emit_end;

   always_comb begin
      for (int j = 0; j < POOL_N; j++) vmask[j] = (j < int'(cnt_q));
   end

   // one comparator per pool slot: row ptr_q against every member
   for (genvar j = 0; j < POOL_N; j++) begin : g_cmp
      pareto_cmp #(.OBJ_W(OBJ_W)) u_cmp (
         .a_time  (t_q[ptr_q]), .a_energy(e_q[ptr_q]), .a_temp(h_q[ptr_q]),
         .b_time  (t_q[j]),     .b_energy(e_q[j]),     .b_temp(h_q[j]),
         .a_dom_b (row_raw[j])
      );
   end

   always_comb begin
      row     = row_raw & vmask;
      row_cnt = '0;
      for (int j = 0; j < POOL_N; j++) row_cnt = row_cnt + STR_W'(row[j]);
      for (int j = 0; j < POOL_N; j++) col[j] = dom_q[j][ptr_q] & vmask[j];
   end

   pareto_colsum #(.N(POOL_N), .STR_W(STR_W), .FIT_W(FIT_W)) u_colsum (
      .col (col), .str (str_q), .sum (col_sum)
   );

   pareto_pick #(.N(POOL_N), .FIT_W(FIT_W), .IDX_W(IDX_W)) u_pick (
      .cand (vmask & ~picked_q), .fit (fit_q), .found (pick_found), .sel (pick_sel)
   );

   always_comb begin
      arc_len  = (cnt_q < CNT_W'(ARC_N)) ? cnt_q : CNT_W'(ARC_N);
      ptr_end  = (CNT_W'(ptr_q) == cnt_q - CNT_W'(1));
      emit_end = (emit_q + CNT_W'(1) == arc_len);
      in_ready = (state_q == ST_LOAD);
      done     = (state_q == ST_DONE);
   end

   // storage without reset: every entry is written before it is read
   always_ff @(posedge clk) begin
      if (state_q == ST_LOAD && in_valid) begin
         t_q[IDX_W'(cnt_q)] <= in_time;
         e_q[IDX_W'(cnt_q)] <= in_energy;
         h_q[IDX_W'(cnt_q)] <= in_temp;
      end
      if (state_q == ST_ROW) begin
         dom_q[ptr_q] <= row;
         str_q[ptr_q] <= row_cnt;
      end
      if (state_q == ST_COL) fit_q[ptr_q] <= col_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_LOAD;
         cnt_q        <= '0;
         ptr_q        <= '0;
         emit_q       <= '0;
         picked_q     <= '0;
         out_valid    <= 1'b0;
         out_last     <= 1'b0;
         out_idx      <= '0;
         out_strength <= '0;
         out_fitness  <= '0;
         out_time     <= '0;
         out_energy   <= '0;
         out_temp     <= '0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         case (state_q)
            ST_LOAD: if (in_valid) begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (in_last || cnt_q == CNT_W'(POOL_N - 1)) begin
                  state_q <= ST_ROW;
                  ptr_q   <= '0;
               end
            end
            ST_ROW: begin
               ptr_q <= ptr_q + IDX_W'(1);
               if (ptr_end) begin
                  state_q <= ST_COL;
                  ptr_q   <= '0;
               end
            end
            ST_COL: begin
               ptr_q <= ptr_q + IDX_W'(1);
               if (ptr_end) state_q <= ST_DONE;
            end
            ST_DONE: begin
               picked_q <= '0;
               emit_q   <= '0;
               state_q  <= ST_EMIT;
            end
            ST_EMIT: begin
               picked_q[pick_sel] <= 1'b1;
               emit_q       <= emit_q + CNT_W'(1);
               out_valid    <= pick_found;
               out_last     <= emit_end;
               out_idx      <= pick_sel;
               out_strength <= str_q[pick_sel];
               out_fitness  <= fit_q[pick_sel];
               out_time     <= t_q[pick_sel];
               out_energy   <= e_q[pick_sel];
               out_temp     <= h_q[pick_sel];
               if (emit_end) begin
                  state_q <= ST_LOAD;
                  cnt_q   <= '0;
               end
            end
            default: state_q <= ST_LOAD;
         endcase
      end
   end
endmodule

// File: rtl/pareto_archiver_chk.sv
module pareto_archiver_chk #(
   parameter int FIT_W   = 9,
   parameter int IDX_W   = 5,
   parameter int MAX_FIT = 300
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             out_valid,
   input logic             out_last,
   input logic [IDX_W-1:0] out_idx,
   input logic [FIT_W-1:0] out_fitness
);
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_fitness) <= MAX_FIT));

   assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |->
         ((out_fitness > $past(out_fitness)) ||
          (out_fitness == $past(out_fitness) && out_idx > $past(out_idx))));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_first_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(done, 2));

   assert_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   assert_last_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid ##1 !out_valid));
endmodule

bind pareto_archiver pareto_archiver_chk #(
   .FIT_W(FIT_W), .IDX_W(IDX_W), .MAX_FIT(MAX_FIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .out_valid(out_valid),
   .out_last(out_last), .out_idx(out_idx), .out_fitness(out_fitness)
);

// File: tb/tb_pareto_archiver.sv
`timescale 1ns/1ps
module tb_pareto_archiver;
   localparam int OBJ_W  = 16;
   localparam int POP_N  = 20;
   localparam int ARC_N  = 5;
   localparam int POOL_N = POP_N + ARC_N;
   localparam int IDX_W  = $clog2(POOL_N);
   localparam int STR_W  = IDX_W;
   localparam int FIT_W  = $clog2(POOL_N * (POOL_N - 1) / 2 + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0;
   logic [OBJ_W-1:0] in_time = '0, in_energy = '0, in_temp = '0;
   logic in_ready, done, out_valid, out_last;
   logic [IDX_W-1:0] out_idx;
   logic [STR_W-1:0] out_strength;
   logic [FIT_W-1:0] out_fitness;
   logic [OBJ_W-1:0] out_time, out_energy, out_temp;

   always #2.5 clk = ~clk;

   pareto_archiver #(.OBJ_W(OBJ_W), .POP_N(POP_N), .ARC_N(ARC_N)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_last(in_last), .in_time(in_time), .in_energy(in_energy), .in_temp(in_temp),
      .done(done), .out_valid(out_valid), .out_last(out_last), .out_idx(out_idx),
      .out_strength(out_strength), .out_fitness(out_fitness),
      .out_time(out_time), .out_energy(out_energy), .out_temp(out_temp)
   );

   typedef struct {
      int idx; int str; int fit; int t; int e; int h; int last;
   } item_t;
   item_t exp_q[$];

   int n_chk = 0, n_fail = 0, done_cnt = 0;
   bit finished = 1'b0;
   int pt[POOL_N], pe[POOL_N], ph[POOL_N];
   int pn;

   task automatic chk(string tag, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // monitor: pop and compare each archive entry as it appears
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) chk("R5 unexpected extra entry", 1, 0);
         else begin
            item_t x;
            x = exp_q.pop_front();
            chk("R6 entry index", int'(out_idx), x.idx);
            chk("R2 strength", int'(out_strength), x.str);
            chk("R3 fitness", int'(out_fitness), x.fit);
            chk("R1 entry time", int'(out_time), x.t);
            chk("R1 entry energy", int'(out_energy), x.e);
            chk("R1 entry temp", int'(out_temp), x.h);
            chk("R5 last flag", int'(out_last), x.last);
         end
      end
      if (rst_n && done) begin
         done_cnt++;
         chk("R7 in_ready low at done", int'(in_ready), 0);
      end
   end

   function automatic bit dominates(int a, int b);
      return (pt[a] <= pt[b] && pe[a] <= pe[b] && ph[a] <= ph[b]) &&
             (pt[a] < pt[b] || pe[a] < pe[b] || ph[a] < ph[b]);
   endfunction

   task automatic push_expected();
      int s[POOL_N], f[POOL_N];
      bit used[POOL_N];
      int alen;
      for (int i = 0; i < pn; i++) begin
         s[i] = 0; f[i] = 0; used[i] = 1'b0;
         for (int j = 0; j < pn; j++) if (dominates(i, j)) s[i]++;
      end
      for (int i = 0; i < pn; i++)
         for (int j = 0; j < pn; j++) if (dominates(j, i)) f[i] += s[j];
      alen = (pn < ARC_N) ? pn : ARC_N;
      for (int k = 0; k < alen; k++) begin
         int b;
         item_t x;
         b = -1;
         for (int i = 0; i < pn; i++)
            if (!used[i] && (b < 0 || f[i] < f[b])) b = i;
         used[b] = 1'b1;
         x.idx = b; x.str = s[b]; x.fit = f[b];
         x.t = pt[b]; x.e = pe[b]; x.h = ph[b];
         x.last = (k == alen - 1) ? 1 : 0;
         exp_q.push_back(x);
      end
   endtask

   task automatic run_pool(bit use_last, bit poke_busy);
      int d0;
      d0 = done_cnt;
      push_expected();
      for (int k = 0; k < pn; k++) begin
         @(negedge clk);
         chk("R7 in_ready during load", int'(in_ready), 1);
         in_valid  = 1'b1;
         in_last   = use_last && (k == pn - 1);
         in_time   = OBJ_W'(pt[k]);
         in_energy = OBJ_W'(pe[k]);
         in_temp   = OBJ_W'(ph[k]);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (poke_busy) begin
         // stray beats while evaluating must be ignored
         for (int k = 0; k < 8; k++) begin
            chk("R7 in_ready low while busy", int'(in_ready), 0);
            in_valid  = 1'b1;
            in_last   = 1'b1;
            in_time   = 16'h0000;
            in_energy = 16'h0000;
            in_temp   = 16'h0000;
            @(negedge clk);
         end
         in_valid = 1'b0;
         in_last  = 1'b0;
      end
      for (int c = 0; c < 400 && exp_q.size() != 0; c++) @(negedge clk);
      chk("R5 all archive entries seen", exp_q.size(), 0);
      exp_q.delete();
      repeat (2) @(negedge clk);
      chk("R8 one done pulse per pool", done_cnt - d0, 1);
      chk("R8 out_valid low after last", int'(out_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 in_ready after reset", int'(in_ready), 1);
      chk("R9 out_valid after reset", int'(out_valid), 0);
      chk("R9 done after reset", int'(done), 0);

      // R3 / R7: full strict chain, ended by capacity, fitness reaches 300
      pn = POOL_N;
      for (int i = 0; i < pn; i++) begin pt[i] = 3*i+1; pe[i] = 2*i+5; ph[i] = i+7; end
      run_pool(1'b0, 1'b0);

      // R5: 20 mutual trade-offs, surplus non-dominated dropped by index; stray beats
      pn = 20;
      for (int i = 0; i < pn; i++) begin pt[i] = i; pe[i] = 100 - i; ph[i] = 50; end
      run_pool(1'b1, 1'b1);

      // R4 / R6: two non-dominated members, shortfall filled from dominated ones
      pn = 8;
      pt[0] = 1; pe[0] = 5; ph[0] = 5;
      pt[1] = 5; pe[1] = 1; ph[1] = 5;
      for (int i = 2; i < pn; i++) begin pt[i] = 4+i; pe[i] = 4+i; ph[i] = 6; end
      pt[7] = 6; pe[7] = 6; ph[7] = 6;
      run_pool(1'b1, 1'b0);

      // R1: identical members never dominate each other
      pn = 6;
      for (int i = 0; i < pn; i++) begin pt[i] = 9; pe[i] = 9; ph[i] = 9; end
      run_pool(1'b1, 1'b0);

      // R1 / R5: single-cost difference, pool smaller than the archive
      pn = 3;
      pt[0] = 1; pe[0] = 2; ph[0] = 3;
      pt[1] = 1; pe[1] = 2; ph[1] = 4;
      pt[2] = 2; pe[2] = 2; ph[2] = 3;
      run_pool(1'b1, 1'b0);

      // R5: pool of one
      pn = 1; pt[0] = 65535; pe[0] = 0; ph[0] = 65535;
      run_pool(1'b1, 1'b0);

      // R6: random pools with narrow cost ranges to force ties
      for (int r = 0; r < 12; r++) begin
         pn = 1 + int'($urandom_range(POOL_N - 1, 0));
         for (int i = 0; i < pn; i++) begin
            pt[i] = int'($urandom_range(3, 0));
            pe[i] = int'($urandom_range(3, 0));
            ph[i] = int'($urandom_range(3, 0));
         end
         run_pool(pn != POOL_N || r[0], 1'b0);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule